// File: doc/BRIEF.md
# Multi-Locality Ownership Arbiter

This block decides which of five localities (0 to 4) owns a shared register window at any moment. Each locality has its own 8-bit access register, placed at the start of its own 4 KB page. All five registers are views of one ownership state. A locality asks for ownership by writing the request bit into its own register. The current owner gives ownership up by writing the active bit into its own register.

The block holds the owner and the set of outstanding requests. When nobody owns the window, it grants the highest-numbered requester on the next clock edge. It reports through each access register whether that locality owns the window, whether others are waiting, whether its own request is outstanding, and whether the state is settled. Each change of owner raises a one-cycle event pulse that an interrupt controller can latch.

The register port is a plain address/write-strobe port with combinational read data. The bus protocol in front of it, the command engine and the data path are outside this block.

Top module: `loc_arb_top`

## Requirements
- R1: After reset no locality owns the window and no request is outstanding. Every access register reads 0x80 and `loc_change_evt` is 0.
- R2: The access register of locality L sits at byte address L×0x1000 (address bits [15:12] = L, bits [11:0] = 0, L in 0..4). Any other address reads 0x00, and a write to it changes nothing.
- R3: A write with bit 1 (0x02) set, made by a locality that does not own the window, marks that locality's request as outstanding. Bit 1 of that locality's register reads 1 while the request is outstanding.
- R4: In a cycle with no owner and at least one outstanding request, the next clock edge makes the highest-numbered requester the owner and clears its request.
- R5: A write with bit 5 (0x20) set into the owner's register leaves the window without an owner after that edge. If requests are outstanding, the following edge grants the highest of them.
- R6: Bit 5 reads 1 only in the owner's register and only while an owner exists.
- R7: Bit 2 (0x04) reads 1 in the owner's register exactly when some other locality has a request outstanding. It reads 0 in every other register.
- R8: Bit 7 reads 1 in all five registers, except in cycles with no owner while a request is outstanding, when it reads 0.
- R9: `loc_change_evt` is high for exactly the one cycle after each edge that changes the owner (gain, loss or handover), and low otherwise.
- R10: These writes have no effect: a request from the owner, a request from the locality that the same edge grants, and a bit-5 write from a locality that does not own the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| owner_valid | output | 1 | An owner exists |
| owner_id | output | 3 | Index of the owning locality |
| loc_change_evt | output | 1 | One-cycle pulse after an owner change |

## Verification
The assertions assume one register write per cycle, `bus_wr` and address settled before the edge, and a reset that is held for at least one edge before the first access. The bench drives inputs only at the falling edge, with one write per step. It makes its random writes from a mix of request, relinquish, combined and arbitrary data patterns to pages 0 to 5, with zero and non-zero page offsets. Page 5 and the non-zero offsets exercise the decode misses. Every step is checked against a bench-side ownership model.

// File: rtl/loc_arb_pkg.sv
package loc_arb_pkg;
    localparam int REG_W       = 8;
    localparam int VALID_BIT   = 7;
    localparam int ACTIVE_BIT  = 5;
    localparam int PENDING_BIT = 2;
    localparam int REQUEST_BIT = 1;
endpackage

// File: rtl/loc_arb_decode.sv
module loc_arb_decode #(
    parameter int NUM_LOC   = 5,
    parameter int PAGE_BITS = 12,
    parameter int ADDR_W    = 16,
    parameter int LOC_W     = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [LOC_W-1:0]  loc
);
    localparam int PAGE_W = ADDR_W - PAGE_BITS;

    logic [PAGE_W-1:0] page;

    always_comb begin
        page = addr[ADDR_W-1:PAGE_BITS];
        hit  = (addr[PAGE_BITS-1:0] == '0) && (page < PAGE_W'(NUM_LOC));
        loc  = page[LOC_W-1:0];
    end
endmodule

// File: rtl/loc_arb_pick.sv
module loc_arb_pick #(
    parameter int N = 5,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                any = 1'b1;
                idx = W'(i);
            end
        end
    end
endmodule

// File: rtl/loc_arb_readback.sv
module loc_arb_readback
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC = 5,
    parameter int LOC_W   = 3
) (
    input  logic               hit,
    input  logic [LOC_W-1:0]   loc,
    input  logic               own_vld,
    input  logic [LOC_W-1:0]   own_id,
    input  logic [NUM_LOC-1:0] pend,
    output logic [REG_W-1:0]   rdata
);
    logic [NUM_LOC-1:0] per_pend;
    logic [NUM_LOC-1:0] per_own;
    logic [NUM_LOC-1:0] others_wait;

    for (genvar g = 0; g < NUM_LOC; g++) begin : g_loc
        assign per_own[g]     = own_vld && (own_id == LOC_W'(g));
        assign per_pend[g]    = pend[g];
        assign others_wait[g] = per_own[g] && ((pend & ~(NUM_LOC'(1) << g)) != '0);
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata[VALID_BIT]   = own_vld || (pend == '0);
            rdata[ACTIVE_BIT]  = per_own[loc];
            rdata[PENDING_BIT] = others_wait[loc];
            rdata[REQUEST_BIT] = per_pend[loc];
        end
    end
endmodule

// File: rtl/loc_arb_top.sv
module loc_arb_top
    import loc_arb_pkg::*;
#(
    parameter int NUM_LOC   = 5,
    parameter int PAGE_BITS = 12,
    parameter int ADDR_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    output logic                owner_valid,
    output logic [$clog2(NUM_LOC)-1:0] owner_id,
    output logic                loc_change_evt
);
    localparam int LOC_W = $clog2(NUM_LOC);

    typedef struct packed {
        logic               own_vld;
        logic [LOC_W-1:0]   own_id;
        logic [NUM_LOC-1:0] pend;
        logic               evt;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic             acc_hit;
    logic [LOC_W-1:0] acc_loc;
    logic             pick_any;
    logic [LOC_W-1:0] pick_idx;
    logic             wr_hit;
    logic             is_owner_q;

    loc_arb_decode #(
        .NUM_LOC  (NUM_LOC),
        .PAGE_BITS(PAGE_BITS),
        .ADDR_W   (ADDR_W),
        .LOC_W    (LOC_W)
    ) decode_i (
        .addr(bus_addr),
        .hit (acc_hit),
        .loc (acc_loc)
    );

    loc_arb_pick #(
        .N(NUM_LOC),
        .W(LOC_W)
    ) pick_i (
        .req(st_q.pend),
        .any(pick_any),
        .idx(pick_idx)
    );

    loc_arb_readback #(
        .NUM_LOC(NUM_LOC),
        .LOC_W  (LOC_W)
    ) readback_i (
        .hit    (acc_hit),
        .loc    (acc_loc),
        .own_vld(st_q.own_vld),
        .own_id (st_q.own_id),
        .pend   (st_q.pend),
        .rdata  (bus_rdata)
    );

    always_comb begin
        st_d       = st_q;
        st_d.evt   = 1'b0;
        wr_hit     = bus_wr && acc_hit;
        is_owner_q = st_q.own_vld && (st_q.own_id == acc_loc);

        // grant when the window is free
        if (!st_q.own_vld && pick_any) begin
            st_d.own_vld        = 1'b1;
            st_d.own_id         = pick_idx;
            st_d.pend[pick_idx] = 1'b0;
        end

        // relinquish by the owner only
        if (wr_hit && bus_wdata[ACTIVE_BIT] && is_owner_q) begin
            st_d.own_vld = 1'b0;
        end

        // request from anyone who neither owns nor is being granted
        if (wr_hit && bus_wdata[REQUEST_BIT] && !is_owner_q &&
            !(st_d.own_vld && (st_d.own_id == acc_loc))) begin
            st_d.pend[acc_loc] = 1'b1;
        end

        st_d.evt = (st_d.own_vld != st_q.own_vld) ||
                   (st_d.own_vld && (st_d.own_id != st_q.own_id));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign owner_valid    = st_q.own_vld;
    assign owner_id       = st_q.own_id;
    assign loc_change_evt = st_q.evt;

    // R10
    owner_not_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.own_vld |-> !st_q.pend[st_q.own_id]);

    // R4
    idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.own_vld && st_q.pend != '0) |=> st_q.own_vld);

    // R4
    grant_highest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.own_vld && st_q.pend != '0) |=> (($past(st_q.pend) >> st_q.own_id) == NUM_LOC'(1)));

    // R9
    evt_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((owner_valid != $past(owner_valid)) ||
         (owner_valid && owner_id != $past(owner_id))) |-> loc_change_evt);

    // R9
    evt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(owner_valid) && $stable(owner_id)) |-> !loc_change_evt);

    // R10
    foreign_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.own_vld && bus_wr && acc_hit && acc_loc != st_q.own_id) |=>
        (st_q.own_vld && $stable(st_q.own_id)));

    // R6
    active_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_hit && bus_rdata[ACTIVE_BIT]) |-> (st_q.own_vld && acc_loc == st_q.own_id));
endmodule

// File: tb/loc_arb_top_tb.sv
`timescale 1ns/100ps
module loc_arb_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        owner_valid;
    logic [2:0]  owner_id;
    logic        loc_change_evt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench-side ownership model
    bit       m_vld;
    int       m_id;
    bit [4:0] m_pend;

    always #5 clk = ~clk;

    loc_arb_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .owner_valid(owner_valid),
        .owner_id(owner_id), .loc_change_evt(loc_change_evt)
    );

    function automatic int highest(bit [4:0] p);
        int h = 0;
        for (int i = 0; i < 5; i++) if (p[i]) h = i;
        return h;
    endfunction

    function automatic bit addr_hit(logic [15:0] a);
        return (a[11:0] == 12'h0) && (a[15:12] < 4'd5);
    endfunction

    function automatic int exp_rd(logic [15:0] a);
        int l;
        int r = 0;
        if (!addr_hit(a)) return 0;
        l = int'(a[15:12]);
        if (m_vld || m_pend == 5'b0) r |= 8'h80;
        if (m_vld && m_id == l) r |= 8'h20;
        if (m_vld && m_id == l && (m_pend & ~(5'b1 << l)) != 5'b0) r |= 8'h04;
        if (m_pend[l]) r |= 8'h02;
        return r;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a);
        bus_addr = a;
        #0.2;
        chk(tag, int'(bus_rdata), exp_rd(a));
    endtask

    task automatic step(input bit wr, input logic [15:0] a, input logic [7:0] d);
        bit       nv;
        int       ni;
        bit [4:0] np;
        bit       ne;
        int       l;
        bit       h;
        h  = addr_hit(a);
        l  = int'(a[15:12]);
        nv = m_vld; ni = m_id; np = m_pend;
        if (!m_vld && m_pend != 5'b0) begin
            nv = 1'b1; ni = highest(m_pend); np[ni] = 1'b0;
        end
        if (wr && h && d[5] && m_vld && l == m_id) nv = 1'b0;
        if (wr && h && d[1] && !(m_vld && l == m_id) && !(nv && l == ni)) np[l] = 1'b1;
        ne = (nv != m_vld) || (nv && ni != m_id);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        m_vld = nv; m_id = nv ? ni : m_id; m_pend = np;
        chk("R4 owner_valid", int'(owner_valid), int'(m_vld));
        if (m_vld) chk("R4 owner_id", int'(owner_id), m_id);
        chk("R9 loc_change_evt", int'(loc_change_evt), int'(ne));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_vld = 1'b0; m_id = 0; m_pend = 5'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 owner_valid", int'(owner_valid), 0);
        chk("R1 evt", int'(loc_change_evt), 0);
        for (int l = 0; l < 5; l++) begin
            bus_addr = 16'(l << 12);
            #0.2;
            chk("R1 access reads 0x80", int'(bus_rdata), 8'h80);
        end

        // R3 request from idle, R8 valid low while grant pending
        step(1'b1, 16'h2000, 8'h02);
        rd_chk("R3 request bit visible", 16'h2000);
        chk("R8 valid low in pending idle", int'(bus_rdata), 8'h02);
        // R4 grant next edge, R9 pulse
        step(1'b0, 16'h0000, 8'h00);
        chk("R4 loc2 granted", int'(owner_id), 2);
        chk("R9 evt on grant", int'(loc_change_evt), 1);
        rd_chk("R6 owner active bit", 16'h2000);
        chk("R6 owner reads 0xA0", int'(bus_rdata), 8'hA0);
        // R10 owner request ignored
        step(1'b1, 16'h2000, 8'h02);
        rd_chk("R10 owner request ignored", 16'h2000);
        chk("R10 owner still 0xA0", int'(bus_rdata), 8'hA0);
        // R7 others waiting
        step(1'b1, 16'h4000, 8'h02);
        step(1'b1, 16'h1000, 8'h02);
        rd_chk("R7 pending seen by owner", 16'h2000);
        chk("R7 owner reads 0xA4", int'(bus_rdata), 8'hA4);
        rd_chk("R7 non-owner sees no pending bit", 16'h4000);
        chk("R7 loc4 reads 0x82", int'(bus_rdata), 8'h82);
        // R10 non-owner relinquish ignored
        step(1'b1, 16'h4000, 8'h20);
        chk("R10 foreign release ignored", int'(owner_id), 2);
        // R2 decode misses
        step(1'b1, 16'h2004, 8'h20);
        chk("R2 offset write ignored", int'(owner_valid), 1);
        rd_chk("R2 offset read zero", 16'h2004);
        step(1'b1, 16'h5000, 8'h02);
        rd_chk("R2 page5 read zero", 16'h5000);
        rd_chk("R2 page5 no request", 16'h1000);
        // R5 relinquish then handover to highest
        step(1'b1, 16'h2000, 8'h20);
        chk("R5 idle after release", int'(owner_valid), 0);
        chk("R9 evt on release", int'(loc_change_evt), 1);
        rd_chk("R8 loc0 valid low", 16'h0000);
        step(1'b0, 16'h0000, 8'h00);
        chk("R5 handover to loc4", int'(owner_id), 4);
        rd_chk("R7 loc4 sees loc1 waiting", 16'h4000);

        // random phase
        for (int n = 0; n < 800; n++) begin
            logic [15:0] a;
            logic [7:0]  d;
            int          sel;
            a = 16'($urandom_range(0, 5) << 12);
            if ($urandom_range(0, 9) == 0) a[3:0] = 4'($urandom_range(1, 15));
            sel = $urandom_range(0, 4);
            d = (sel == 0) ? 8'h02 : (sel == 1) ? 8'h20 : (sel == 2) ? 8'h22 :
                (sel == 3) ? 8'h00 : 8'($urandom());
            step($urandom_range(0, 3) != 0, a, d);
            rd_chk("R6 R7 R8 random readback", 16'($urandom_range(0, 4) << 12));
            rd_chk("R3 random readback", 16'($urandom_range(0, 5) << 12));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule